// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps calendar time in eight separate counters: second, minute, hour, day of week, day of month, day of year, month and year. A prescaler divides the system clock down to a one-second tick. Each tick advances the seconds counter, and carries ripple up through the higher fields within the same clock cycle. Month lengths follow the calendar, and February gets a 29th day in any year divisible by 4.

Software reaches the block over a simple 32-bit register bus. Each counter can be written on its own. Three packed read-only words present the whole calendar, so a reader needs fewer accesses. An alarm comparator checks each field against its own target, and a per-field ignore mask can leave any field out of the comparison. Per-field increment enables raise a separate event when chosen fields advance. Both events are latched in a status register. One interrupt line is high while either event is latched.

Register offsets (byte addresses, word aligned): status 0x00, control 0x08, increment enables 0x0C, alarm ignore mask 0x10, packed words 0x14/0x18/0x1C, counters 0x20–0x3C, trim storage 0x40, scratch words 0x44–0x50, alarm targets 0x60–0x7C. Counters and alarm targets use the field order second, minute, hour, day of month, day of week, day of year, month, year. The per-field bits in the mask and enable registers use that same order, bit 0 to bit 7.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the control register reads 0, the alarm ignore mask reads 0xFF, status reads 0 and irq is low. Second, minute, hour, day of week and year read 0. Day of month, day of year and month read 1.
- R2: While control bit 0 (run) is 1 and control bit 1 (prescaler hold) is 0, one tick occurs every TICK_DIV clock cycles. No tick occurs while run is 0 or hold is 1, and hold keeps the prescaler count at zero.
- R3: On a tick the second advances. Second and minute wrap from 59 to 0 and carry into the next field. Hour wraps from 23 to 0 and starts a new day. On a new day, day of week wraps from 6 to 0.
- R4: On a new day, day of month wraps to 1 after the last day of the month and the month then advances. April, June, September and November have 30 days. February has 28 days, or 29 when year mod 4 is 0. All other months have 31 days. Month wraps from 12 to 1 and the year then increments.
- R5: On a new day, day of year wraps to 1 after day 365, or after day 366 when year mod 4 is 0. Otherwise it increments.
- R6: Packed word 0x14 holds day of week in [26:24], hour in [20:16], minute in [13:8] and second in [5:0]. Word 0x18 holds year in [27:16], month in [11:8] and day of month in [4:0]. Word 0x1C holds day of year in [11:0]. All other bits read 0.
- R7: A write to any counter register loads that field, truncated to its width, and restarts the prescaler. The next tick then comes TICK_DIV cycles after the write.
- R8: On a tick, status bit 1 (alarm) is set when every field whose ignore-mask bit is 0 equals its alarm target. The comparison uses the updated calendar. A mask of 0xFF never raises the alarm. The bit stays set until software writes 1 to it.
- R9: On a tick, status bit 0 (increment event) is set when any field that advanced on that tick has its enable bit set in register 0x0C. The bit stays set until software writes 1 to it.
- R10: irq is high exactly while status bit 0 or status bit 1 is set.
- R11: Register reads return the stored value masked to the register's width. Control keeps bits 0, 1 and 4. Trim storage keeps bits 17:0. Scratch words keep all 32 bits. Each alarm target keeps its field's width (second and minute 6 bits, hour and day of month 5 bits, day of week 3 bits, day of year 9 bits, month 4 bits, year 12 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | High while an alarm or increment event is latched |

## Verification
The bench builds the block with TICK_DIV set to 4, so that every simulated second lasts four clock cycles. With this setting, full carry chains, leap-February and year-end rollovers take only a handful of ticks each. The bench can also place a counter write at a known prescaler phase, which shows the restart directly: a read on the cycle where the old phase would have ticked still returns the written value. The remaining parameters keep their defaults, which places the scratch words at offsets 0x44–0x50.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NFIELD = 8;
    localparam int FW_MAX = 12;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DOM  = 3'd3,
        F_DOW  = 3'd4,
        F_DOY  = 3'd5,
        F_MON  = 3'd6,
        F_YEAR = 3'd7
    } field_e;

    typedef struct packed {
        logic [11:0] year;
        logic [3:0]  mon;
        logic [8:0]  doy;
        logic [2:0]  dow;
        logic [4:0]  dom;
        logic [4:0]  hour;
        logic [5:0]  min;
        logic [5:0]  sec;
    } cal_t;

    typedef logic [NFIELD-1:0][FW_MAX-1:0] field_vec_t;

    // word indices (byte address / 4)
    localparam int W_STATUS = 'h00;
    localparam int W_CTRL   = 'h02;
    localparam int W_INCEN  = 'h03;
    localparam int W_MASK   = 'h04;
    localparam int W_SNAP0  = 'h05;
    localparam int W_SNAP1  = 'h06;
    localparam int W_SNAP2  = 'h07;
    localparam int W_CNT0   = 'h08;
    localparam int W_TRIM   = 'h10;
    localparam int W_GP0    = 'h11;
    localparam int W_ALM0   = 'h18;

    localparam int TRIM_W = 18;

    function automatic field_vec_t cal_to_vec(input cal_t c);
        field_vec_t v;
        v = '0;
        v[F_SEC]  = {6'b0, c.sec};
        v[F_MIN]  = {6'b0, c.min};
        v[F_HOUR] = {7'b0, c.hour};
        v[F_DOM]  = {7'b0, c.dom};
        v[F_DOW]  = {9'b0, c.dow};
        v[F_DOY]  = {3'b0, c.doy};
        v[F_MON]  = {8'b0, c.mon};
        v[F_YEAR] = c.year;
        return v;
    endfunction

    function automatic logic [FW_MAX-1:0] field_mask(input int unsigned idx);
        case (idx)
            0, 1:    return 12'h03F;
            2, 3:    return 12'h01F;
            4:       return 12'h007;
            5:       return 12'h1FF;
            6:       return 12'h00F;
            default: return 12'hFFF;
        endcase
    endfunction

    function automatic logic is_leap(input logic [11:0] y);
        return (y[1:0] == 2'b00);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        case (m)
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            4'd2:                    return leap ? 5'd29 : 5'd28;
            default:                 return 5'd31;
        endcase
    endfunction

    function automatic cal_t cal_reset();
        cal_t c;
        c      = '0;
        c.dom  = 5'd1;
        c.doy  = 9'd1;
        c.mon  = 4'd1;
        return c;
    endfunction

    function automatic logic [31:0] pack_clock(input cal_t c);
        return {5'b0, c.dow, 3'b0, c.hour, 2'b0, c.min, 2'b0, c.sec};
    endfunction

    function automatic logic [31:0] pack_date(input cal_t c);
        return {4'b0, c.year, 4'b0, c.mon, 3'b0, c.dom};
    endfunction

    function automatic logic [31:0] pack_yday(input cal_t c);
        return {20'b0, 3'b0, c.doy};
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768,
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          hold,
    input  logic          restart,
    output logic          tick,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick  = run && !hold && !restart && (cnt_q == LAST);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NFIELD-1:0] wr_sel,
    input  logic [31:0]       wr_data,
    output cal_t              cur,
    output cal_t              nxt,
    output logic [NFIELD-1:0] bumped
);
    cal_t       cal_q;
    logic       c_min, c_hour, c_day, c_mon;
    logic       leap;
    logic [4:0] mlen;
    logic [8:0] ylen;

    assign cur  = cal_q;
    assign leap = is_leap(cal_q.year);
    assign mlen = month_len(cal_q.mon, leap);
    assign ylen = leap ? 9'd366 : 9'd365;

    always_comb begin
        nxt    = cal_q;
        bumped = '0;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        if (tick) begin
            bumped[F_SEC] = 1'b1;
            if (cal_q.sec >= 6'd59) begin
                nxt.sec = 6'd0;
                c_min   = 1'b1;
            end else begin
                nxt.sec = cal_q.sec + 6'd1;
            end
        end
        if (c_min) begin
            bumped[F_MIN] = 1'b1;
            if (cal_q.min >= 6'd59) begin
                nxt.min = 6'd0;
                c_hour  = 1'b1;
            end else begin
                nxt.min = cal_q.min + 6'd1;
            end
        end
        if (c_hour) begin
            bumped[F_HOUR] = 1'b1;
            if (cal_q.hour >= 5'd23) begin
                nxt.hour = 5'd0;
                c_day    = 1'b1;
            end else begin
                nxt.hour = cal_q.hour + 5'd1;
            end
        end
        if (c_day) begin
            bumped[F_DOW] = 1'b1;
            bumped[F_DOM] = 1'b1;
            bumped[F_DOY] = 1'b1;
            nxt.dow = (cal_q.dow >= 3'd6) ? 3'd0 : cal_q.dow + 3'd1;
            nxt.doy = (cal_q.doy >= ylen) ? 9'd1 : cal_q.doy + 9'd1;
            if (cal_q.dom >= mlen) begin
                nxt.dom = 5'd1;
                c_mon   = 1'b1;
            end else begin
                nxt.dom = cal_q.dom + 5'd1;
            end
        end
        if (c_mon) begin
            bumped[F_MON] = 1'b1;
            if (cal_q.mon >= 4'd12) begin
                nxt.mon        = 4'd1;
                nxt.year       = cal_q.year + 12'd1;
                bumped[F_YEAR] = 1'b1;
            end else begin
                nxt.mon = cal_q.mon + 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= cal_reset();
        end else if (|wr_sel) begin
            if (wr_sel[F_SEC])  cal_q.sec  <= wr_data[5:0];
            if (wr_sel[F_MIN])  cal_q.min  <= wr_data[5:0];
            if (wr_sel[F_HOUR]) cal_q.hour <= wr_data[4:0];
            if (wr_sel[F_DOM])  cal_q.dom  <= wr_data[4:0];
            if (wr_sel[F_DOW])  cal_q.dow  <= wr_data[2:0];
            if (wr_sel[F_DOY])  cal_q.doy  <= wr_data[8:0];
            if (wr_sel[F_MON])  cal_q.mon  <= wr_data[3:0];
            if (wr_sel[F_YEAR]) cal_q.year <= wr_data[11:0];
        end else if (tick) begin
            cal_q <= nxt;
        end
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  field_vec_t        now,
    input  field_vec_t        target,
    input  logic [NFIELD-1:0] ignore,
    output logic              hit
);
    logic [NFIELD-1:0] field_ok;

    for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
        assign field_ok[i] = ignore[i] || (now[i] == target[i]);
    end

    assign hit = (&field_ok) && !(&ignore);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int TICK_DIV = 32768,
    parameter int ADDR_W   = 8,
    parameter int GP_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int CNT_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_hit, rd_hit;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_wr && aligned;
    assign rd_hit  = bus_rd && aligned;

    // control and configuration state
    logic                     run_q, hold_q, trimoff_q;
    logic [NFIELD-1:0]        inc_en_q, mask_q;
    logic [TRIM_W-1:0]        trim_q;
    logic [GP_WORDS-1:0][31:0] gp_q;
    field_vec_t               alm_q;
    logic                     flag_alm_q, flag_inc_q;
    logic [31:0]              rdata_q;

    // counter write decode
    logic [NFIELD-1:0] cnt_wr_sel;
    logic              cnt_wr_any;
    for (genvar i = 0; i < NFIELD; i++) begin : g_cnt_sel
        assign cnt_wr_sel[i] = wr_hit && (word == WORD_W'(W_CNT0 + i));
    end
    assign cnt_wr_any = |cnt_wr_sel;

    // prescaler
    logic             tick;
    logic [CNT_W-1:0] presc_cnt;

    rtc_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .hold    (hold_q),
        .restart (cnt_wr_any),
        .tick    (tick),
        .count   (presc_cnt)
    );

    // calendar counters
    cal_t              cal_cur, cal_nxt;
    logic [NFIELD-1:0] bumped;

    rtc_cal_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_sel  (cnt_wr_sel),
        .wr_data (bus_wdata),
        .cur     (cal_cur),
        .nxt     (cal_nxt),
        .bumped  (bumped)
    );

    field_vec_t cur_vec, nxt_vec;
    assign cur_vec = cal_to_vec(cal_cur);
    assign nxt_vec = cal_to_vec(cal_nxt);

    // alarm comparator on the updated calendar
    logic alarm_hit;
    rtc_alarm_match u_match (
        .now    (nxt_vec),
        .target (alm_q),
        .ignore (mask_q),
        .hit    (alarm_hit)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            hold_q    <= 1'b0;
            trimoff_q <= 1'b0;
            inc_en_q  <= '0;
            mask_q    <= '1;
            trim_q    <= '0;
        end else if (wr_hit) begin
            if (word == WORD_W'(W_CTRL)) begin
                run_q     <= bus_wdata[0];
                hold_q    <= bus_wdata[1];
                trimoff_q <= bus_wdata[4];
            end
            if (word == WORD_W'(W_INCEN)) inc_en_q <= bus_wdata[NFIELD-1:0];
            if (word == WORD_W'(W_MASK))  mask_q   <= bus_wdata[NFIELD-1:0];
            if (word == WORD_W'(W_TRIM))  trim_q   <= bus_wdata[TRIM_W-1:0];
        end
    end

    for (genvar i = 0; i < NFIELD; i++) begin : g_alm
        always_ff @(posedge clk) begin
            if (rst) begin
                alm_q[i] <= '0;
            end else if (wr_hit && (word == WORD_W'(W_ALM0 + i))) begin
                alm_q[i] <= bus_wdata[FW_MAX-1:0] & field_mask(i);
            end
        end
    end

    for (genvar g = 0; g < GP_WORDS; g++) begin : g_gp
        always_ff @(posedge clk) begin
            if (rst) begin
                gp_q[g] <= '0;
            end else if (wr_hit && (word == WORD_W'(W_GP0 + g))) begin
                gp_q[g] <= bus_wdata;
            end
        end
    end

    // status flags: set wins over a clear in the same cycle
    logic status_wr;
    assign status_wr = wr_hit && (word == WORD_W'(W_STATUS));

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_alm_q <= 1'b0;
            flag_inc_q <= 1'b0;
        end else begin
            if (status_wr && bus_wdata[0]) flag_inc_q <= 1'b0;
            if (status_wr && bus_wdata[1]) flag_alm_q <= 1'b0;
            if (tick && |(bumped & inc_en_q)) flag_inc_q <= 1'b1;
            if (tick && alarm_hit)            flag_alm_q <= 1'b1;
        end
    end

    assign irq = flag_alm_q | flag_inc_q;

    // read path
    logic [31:0] rd_val;
    always_comb begin
        rd_val = '0;
        if (word == WORD_W'(W_STATUS)) rd_val = {30'b0, flag_alm_q, flag_inc_q};
        if (word == WORD_W'(W_CTRL))   rd_val = {27'b0, trimoff_q, 2'b0, hold_q, run_q};
        if (word == WORD_W'(W_INCEN))  rd_val = {{(32-NFIELD){1'b0}}, inc_en_q};
        if (word == WORD_W'(W_MASK))   rd_val = {{(32-NFIELD){1'b0}}, mask_q};
        if (word == WORD_W'(W_SNAP0))  rd_val = pack_clock(cal_cur);
        if (word == WORD_W'(W_SNAP1))  rd_val = pack_date(cal_cur);
        if (word == WORD_W'(W_SNAP2))  rd_val = pack_yday(cal_cur);
        if (word == WORD_W'(W_TRIM))   rd_val = {{(32-TRIM_W){1'b0}}, trim_q};
        for (int i = 0; i < NFIELD; i++) begin
            if (word == WORD_W'(W_CNT0 + i)) rd_val = {{(32-FW_MAX){1'b0}}, cur_vec[i]};
            if (word == WORD_W'(W_ALM0 + i)) rd_val = {{(32-FW_MAX){1'b0}}, alm_q[i]};
        end
        for (int g = 0; g < GP_WORDS; g++) begin
            if (word == WORD_W'(W_GP0 + g)) rd_val = gp_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_hit) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
    parameter int CNT_W  = 15,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              tick,
    input logic              run,
    input logic              hold,
    input logic              cnt_wr_any,
    input logic [CNT_W-1:0]  presc_cnt,
    input logic [5:0]        sec,
    input logic              inc_en0,
    input logic              flag_alm,
    input logic              flag_inc,
    input logic [7:0]        mask
);
    logic alm_clear;
    assign alm_clear = bus_wr && (bus_addr == '0) && bus_wdata[1];

    // R2: a tick only while running and not held
    a_r2_tick_gated: assert property (@(posedge clk) disable iff (rst)
        tick |-> (run && !hold));

    // R3: seconds step by one and wrap after 59
    a_r3_sec_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> (sec == (($past(sec) >= 6'd59) ? 6'd0 : $past(sec) + 6'd1)));

    // R7: counter writes restart the prescaler
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        cnt_wr_any |=> (presc_cnt == '0));

    // R8: alarm flag is sticky until written with 1
    a_r8_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_alm && !alm_clear) |=> flag_alm);

    // R8: full mask never raises the alarm
    a_r8_mask_off: assert property (@(posedge clk) disable iff (rst)
        (mask == 8'hFF && !flag_alm) |=> !flag_alm);

    // R9: seconds advance on every tick, so an enabled seconds bit must flag
    a_r9_inc_sec: assert property (@(posedge clk) disable iff (rst)
        (tick && inc_en0) |=> flag_inc);

    // R10: the line rises only together with a flag
    a_r10_irq_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($rose(flag_alm) || $rose(flag_inc)));

endmodule

bind rtc_calendar rtc_calendar_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .tick       (tick),
    .run        (run_q),
    .hold       (hold_q),
    .cnt_wr_any (cnt_wr_any),
    .presc_cnt  (presc_cnt),
    .sec        (cal_cur.sec),
    .inc_en0    (inc_en_q[0]),
    .flag_alm   (flag_alm_q),
    .flag_inc   (flag_inc_q),
    .mask       (mask_q)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar #(.TICK_DIV(DIV)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // monitor: compares registered read data one edge after the strobe
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL scoreboard: read with no expected item");
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        bus_write(8'h08, 32'h1);
        repeat (4 * n) @(negedge clk);
        bus_write(8'h08, 32'h2);
    endtask

    task automatic set_time(input int yr, input int mo, input int dm, input int dw,
                            input int dy, input int hr, input int mi, input int se);
        bus_write(8'h20, 32'd0);
        bus_write(8'h3C, 32'(yr));
        bus_write(8'h38, 32'(mo));
        bus_write(8'h2C, 32'(dm));
        bus_write(8'h30, 32'(dw));
        bus_write(8'h34, 32'(dy));
        bus_write(8'h28, 32'(hr));
        bus_write(8'h24, 32'(mi));
        bus_write(8'h20, 32'(se));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(32'(irq), 32'd0, "R1 irq after reset");
        bus_read(8'h08, 32'h0, "R1 control");
        bus_read(8'h10, 32'hFF, "R1 alarm mask");
        bus_read(8'h00, 32'h0, "R1 status");
        bus_read(8'h20, 32'd0, "R1 second");
        bus_read(8'h2C, 32'd1, "R1 day of month");
        bus_read(8'h34, 32'd1, "R1 day of year");
        bus_read(8'h38, 32'd1, "R1 month");
        bus_read(8'h14, 32'h0, "R1 R6 packed clock");
        bus_read(8'h18, 32'h0000_0101, "R1 R6 packed date");
        bus_read(8'h1C, 32'h1, "R1 R6 packed day of year");

        // R2 no counting while stopped or held
        repeat (12) @(negedge clk);
        bus_read(8'h20, 32'd0, "R2 stopped");
        bus_write(8'h08, 32'h3);
        repeat (12) @(negedge clk);
        bus_write(8'h08, 32'h2);
        bus_read(8'h20, 32'd0, "R2 held");
        run_ticks(3);
        bus_read(8'h20, 32'd3, "R2 three ticks");
        bus_read(8'h00, 32'h0, "R8 full mask no alarm");

        // R3 R4 R5 year-end cascade
        set_time(2023, 12, 31, 6, 365, 23, 59, 59);
        run_ticks(1);
        bus_read(8'h14, 32'h0, "R3 R6 clock rolled");
        bus_read(8'h18, 32'h07E8_0101, "R4 R6 new year");
        bus_read(8'h1C, 32'h1, "R5 day of year wrap 365");

        // R4 R5 leap February
        set_time(2024, 2, 28, 3, 365, 23, 59, 59);
        run_ticks(1);
        bus_read(8'h2C, 32'd29, "R4 leap day 29");
        bus_read(8'h38, 32'd2, "R4 still February");
        bus_read(8'h34, 32'd366, "R5 day 366 in leap year");
        bus_read(8'h30, 32'd4, "R3 day of week step");
        bus_write(8'h20, 32'd0);
        bus_write(8'h28, 32'd23);
        bus_write(8'h24, 32'd59);
        bus_write(8'h20, 32'd59);
        run_ticks(1);
        bus_read(8'h18, 32'h07E8_0301, "R4 leap Feb ends after 29");
        bus_read(8'h34, 32'd1, "R5 wrap after 366");

        // R4 plain February and 30-day month
        set_time(2023, 2, 28, 6, 100, 23, 59, 59);
        run_ticks(1);
        bus_read(8'h18, 32'h07E7_0301, "R4 Feb 28 rolls in common year");
        bus_read(8'h34, 32'd101, "R5 day of year step");
        bus_read(8'h30, 32'd0, "R3 day of week wraps 6");
        set_time(2023, 4, 30, 1, 120, 23, 59, 59);
        run_ticks(1);
        bus_read(8'h18, 32'h07E7_0501, "R4 30-day month");

        // R7 counter write restarts prescaler
        bus_write(8'h08, 32'h1);
        bus_write(8'h20, 32'd10);
        repeat (2) @(negedge clk);
        bus_read(8'h20, 32'd10, "R7 no tick before full period");
        bus_read(8'h20, 32'd11, "R7 tick after full period");
        bus_write(8'h08, 32'h2);

        // R8 alarm on seconds only, then sticky, then clear
        set_time(2023, 5, 1, 1, 121, 0, 4, 0);
        bus_write(8'h60, 32'd2);
        bus_write(8'h10, 32'hFE);
        run_ticks(1);
        bus_read(8'h00, 32'h0, "R8 no match at second 1");
        run_ticks(1);
        bus_read(8'h00, 32'h2, "R8 match at second 2");
        check(32'(irq), 32'd1, "R10 irq with alarm");
        run_ticks(1);
        bus_read(8'h00, 32'h2, "R8 alarm sticky");
        bus_write(8'h00, 32'h2);
        bus_read(8'h00, 32'h0, "R8 alarm cleared");
        check(32'(irq), 32'd0, "R10 irq low after clear");
        // minute field compared and different
        bus_write(8'h64, 32'd5);
        bus_write(8'h10, 32'hFC);
        bus_write(8'h20, 32'd1);
        run_ticks(1);
        bus_read(8'h00, 32'h0, "R8 minute mismatch blocks alarm");
        bus_write(8'h10, 32'hFF);

        // R9 increment event on minute only
        bus_write(8'h0C, 32'h02);
        bus_write(8'h20, 32'd58);
        run_ticks(1);
        bus_read(8'h00, 32'h0, "R9 second step not enabled");
        run_ticks(1);
        bus_read(8'h00, 32'h1, "R9 minute step flags");
        check(32'(irq), 32'd1, "R10 irq with increment event");
        bus_write(8'h00, 32'h1);
        bus_read(8'h00, 32'h0, "R9 increment cleared");

        // R11 storage widths
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_read(8'h40, 32'h0003_FFFF, "R11 trim width");
        bus_write(8'h48, 32'hA5A5_1234);
        bus_read(8'h48, 32'hA5A5_1234, "R11 scratch word");
        bus_write(8'h68, 32'hFF);
        bus_read(8'h68, 32'h1F, "R11 alarm hour width");
        bus_read(8'h0C, 32'h02, "R11 increment enables");
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, 32'h13, "R11 control bits");
        bus_write(8'h08, 32'h2);

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: %0d reads never returned", sb_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule